// File: doc/BRIEF.md
# Pulse-Group PWM Generator with Entry FIFO

This block drives one PWM output with finite groups of pulses. Each pulse is an active phase followed by a rest phase. Their lengths come from one of two timing pairs, a primary pair and a shadow pair. After the last pulse of a group the block returns to its idle level. The polarity input picks the level used for the active phase, and the idle level is the opposite one.

There are two modes. In direct mode, a one-cycle `start` launches one group using the primary pair. The pulse count for that group is 14 bits wide and is supplied as an 8-bit low part and a 6-bit high part. In FIFO mode, software pushes 16-bit entries into an 8-deep queue:

- bits [13:0] hold the pulse count;
- bit 14 selects the shadow timing pair for that group;
- bit 15 is reserved and ignored.

The engine pops an entry whenever it is idle and the queue holds one. Groups therefore run one after another until the queue is empty.

Two sticky flags feed the interrupt line. The group-done flag is set at the end of every group while its enable is high. The low-water flag is set while the queue holds fewer entries than a programmable level. Each flag is cleared by a write-1 pulse. The queue reports its occupancy, empty and full, and a flush pulse empties it.

Top module: `pulse_group_pwm`

The engine is a four-state machine:

- IDLE: holds the idle level. It goes to ACTIVE when it loads a non-zero count, to DONE when it loads a zero count, and otherwise stays in IDLE.
- ACTIVE: drives the active level. After the active length it goes to REST.
- REST: drives the idle level. After the rest length it goes back to ACTIVE if pulses remain, or to DONE after the last pulse.
- DONE: lasts one cycle, marks the end of the group, and returns to IDLE.

## Requirements
- R1: After reset the output is at the idle level (equal to `polarity`), the queue is empty with occupancy 0 and not full, and both flags and `irq` are 0.
- R2: In direct mode, a `start` sampled at a clock edge produces N pulses of `act_len_p` active cycles and `rest_len_p` rest cycles, where N = {`grp_len_hi`,`grp_len_lo`}. With the done enable high, `done_flag` reads 1 exactly N*(act+rest)+1 edges after the start edge.
- R3: The active level is 1 when `polarity` is 0 and 0 when `polarity` is 1. The idle level is always equal to `polarity`.
- R4: A pulse count of 0 produces no pulse, and the group completes so that `done_flag` reads 1 one edge after the loading edge.
- R5: In FIFO mode, entries run in push order. Bits [13:0] give the count, bit 14 = 1 selects `act_len_s`/`rest_len_s` for that group, and bit 15 has no effect.
- R6: `fifo_occ` counts the held entries (0 to 8), with `fifo_empty` = (occ==0) and `fifo_full` = (occ==8). A push while full is dropped.
- R7: A `fifo_flush` pulse makes occupancy 0 at the next edge, and a push in that same cycle is dropped.
- R8: `done_flag` is set at the end of a group only when `done_irq_en` is 1. It is cleared by a `clr_done` pulse, and a set in the same cycle wins over the clear.
- R9: `lw_flag` is set on each edge where `lw_irq_en` is 1 and occupancy < `lw_level`. It is cleared by a `clr_lw` pulse, and it sets again while the condition still holds.
- R10: `irq` is 1 exactly when either flag is 1.
- R11: In FIFO mode with `run_en` high and the queue empty, the engine stays idle and the output holds the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Allows the engine to load groups |
| fifo_mode | input | 1 | 1: groups come from the queue; 0: direct mode |
| start | input | 1 | Direct-mode launch pulse |
| grp_len_lo | input | 8 | Direct-mode pulse count, bits 7:0 |
| grp_len_hi | input | 6 | Direct-mode pulse count, bits 13:8 |
| act_len_p | input | 16 | Primary active phase length in cycles (1 or more) |
| rest_len_p | input | 16 | Primary rest phase length in cycles (1 or more) |
| act_len_s | input | 16 | Shadow active phase length in cycles (1 or more) |
| rest_len_s | input | 16 | Shadow rest phase length in cycles (1 or more) |
| polarity | input | 1 | Idle level; the active level is its inverse |
| push | input | 1 | Queue write strobe |
| push_data | input | 16 | Queue entry: [13:0] count, [14] shadow select, [15] reserved |
| fifo_flush | input | 1 | Empties the queue |
| lw_level | input | 4 | Low-water threshold |
| done_irq_en | input | 1 | Enables setting of the group-done flag |
| lw_irq_en | input | 1 | Enables setting of the low-water flag |
| clr_done | input | 1 | Write-1 clear of the group-done flag |
| clr_lw | input | 1 | Write-1 clear of the low-water flag |
| pwm_out | output | 1 | PWM output |
| fifo_occ | output | 4 | Queue occupancy |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| done_flag | output | 1 | Sticky group-done flag |
| lw_flag | output | 1 | Sticky low-water flag |
| irq | output | 1 | OR of the two flags |

## Verification
The output level follows the state register, so the active level appears in the cycle right after the edge that loads a group. Occupancy changes one edge after a push, pop or flush. Each flag appears one edge after its condition: at group end, the flag rises N*(act+rest)+1 edges after the loading edge. The low-water flag lags occupancy by one further edge. The bench drives every input on the falling edge and samples there. It counts falling-edge samples from the launching edge, so the latency, the active-cycle total and the pulse count of each group are compared with values derived only from N and the phase lengths.

// File: rtl/pgpwm_pkg.sv
package pgpwm_pkg;
    // Engine states; the output level is a function of the state only.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_REST = 2'd2,
        ST_DONE = 2'd3
    } eng_state_t;

    localparam int ENTRY_W = 16;  // width of a queue entry as pushed
    localparam int CNT_W   = 14;  // pulse count field [13:0]
    localparam int SEL_BIT = 14;  // shadow-pair select bit
endpackage

// File: rtl/pgpwm_fifo.sv
module pgpwm_fifo #(
    parameter int DEPTH = 8,   // power of two
    parameter int W     = 15,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [OW-1:0] occ,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign empty   = (occ == '0);
    assign full    = (occ == OW'(DEPTH));
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            occ <= occ + OW'(push_ok) - OW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (occ == OW'(DEPTH)));
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (occ == '0));
endmodule

// File: rtl/pgpwm_engine.sv
module pgpwm_engine
    import pgpwm_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               fifo_mode,
    input  logic               start,
    input  logic [CNT_W-1:0]   direct_cnt,
    input  logic [LEN_W-1:0]   act_p,
    input  logic [LEN_W-1:0]   rest_p,
    input  logic [LEN_W-1:0]   act_s,
    input  logic [LEN_W-1:0]   rest_s,
    input  logic               polarity,
    input  logic               q_empty,
    input  logic [SEL_BIT:0]   q_entry,
    output logic               q_pop,
    output logic               pwm_out,
    output logic               grp_done
);
    eng_state_t        st, nxt;
    logic [CNT_W-1:0]  remaining;
    logic [LEN_W-1:0]  ph_cnt;
    logic              use_shadow;
    logic              load;
    logic [CNT_W-1:0]  load_cnt;
    logic              load_sh;
    logic [LEN_W-1:0]  cur_act, cur_rest;

    assign cur_act  = use_shadow ? act_s  : act_p;
    assign cur_rest = use_shadow ? rest_s : rest_p;

    // Next-state and load decode
    always_comb begin
        nxt      = st;
        q_pop    = 1'b0;
        load     = 1'b0;
        load_cnt = '0;
        load_sh  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (run_en && fifo_mode && !q_empty) begin
                    q_pop    = 1'b1;
                    load     = 1'b1;
                    load_cnt = q_entry[CNT_W-1:0];
                    load_sh  = q_entry[SEL_BIT];
                end else if (run_en && !fifo_mode && start) begin
                    load     = 1'b1;
                    load_cnt = direct_cnt;
                end
                if (load) nxt = (load_cnt == '0) ? ST_DONE : ST_ACT;
            end
            ST_ACT: begin
                if (ph_cnt == cur_act - 1'b1) nxt = ST_REST;
            end
            ST_REST: begin
                if (ph_cnt == cur_rest - 1'b1)
                    nxt = (remaining == CNT_W'(1)) ? ST_DONE : ST_ACT;
            end
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // State register with its phase and group counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            remaining  <= '0;
            ph_cnt     <= '0;
            use_shadow <= 1'b0;
        end else begin
            st <= nxt;
            if (load) begin
                remaining  <= load_cnt;
                use_shadow <= load_sh;
                ph_cnt     <= '0;
            end else if (nxt != st) begin
                ph_cnt <= '0;
                if (st == ST_REST) remaining <= remaining - 1'b1;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        pwm_out  = polarity;
        grp_done = 1'b0;
        unique case (st)
            ST_IDLE: pwm_out  = polarity;
            ST_ACT:  pwm_out  = ~polarity;
            ST_REST: pwm_out  = polarity;
            ST_DONE: grp_done = 1'b1;
        endcase
    end

    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !q_empty);
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> !grp_done);
endmodule

// File: rtl/pulse_group_pwm.sv
module pulse_group_pwm
    import pgpwm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 16,
    localparam int OW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              fifo_mode,
    input  logic              start,
    input  logic [7:0]        grp_len_lo,
    input  logic [5:0]        grp_len_hi,
    input  logic [LEN_W-1:0]  act_len_p,
    input  logic [LEN_W-1:0]  rest_len_p,
    input  logic [LEN_W-1:0]  act_len_s,
    input  logic [LEN_W-1:0]  rest_len_s,
    input  logic              polarity,
    input  logic              push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic              fifo_flush,
    input  logic [OW-1:0]     lw_level,
    input  logic              done_irq_en,
    input  logic              lw_irq_en,
    input  logic              clr_done,
    input  logic              clr_lw,
    output logic              pwm_out,
    output logic [OW-1:0]     fifo_occ,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              done_flag,
    output logic              lw_flag,
    output logic              irq
);
    localparam int QW = SEL_BIT + 1;

    logic [QW-1:0] q_head;
    logic          q_pop;
    logic          grp_done;
    logic          unused_rsvd;

    assign unused_rsvd = push_data[ENTRY_W-1];

    pgpwm_fifo #(.DEPTH(DEPTH), .W(QW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_flush),
        .push  (push),
        .wdata (push_data[QW-1:0]),
        .pop   (q_pop),
        .rdata (q_head),
        .occ   (fifo_occ),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pgpwm_engine #(.LEN_W(LEN_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .fifo_mode  (fifo_mode),
        .start      (start),
        .direct_cnt ({grp_len_hi, grp_len_lo}),
        .act_p      (act_len_p),
        .rest_p     (rest_len_p),
        .act_s      (act_len_s),
        .rest_s     (rest_len_s),
        .polarity   (polarity),
        .q_empty    (fifo_empty),
        .q_entry    (q_head),
        .q_pop      (q_pop),
        .pwm_out    (pwm_out),
        .grp_done   (grp_done)
    );

    // Sticky flags: a set in the same cycle wins over the write-1 clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            lw_flag   <= 1'b0;
        end else begin
            if (grp_done && done_irq_en)             done_flag <= 1'b1;
            else if (clr_done)                       done_flag <= 1'b0;
            if (lw_irq_en && (fifo_occ < lw_level))  lw_flag   <= 1'b1;
            else if (clr_lw)                         lw_flag   <= 1'b0;
        end
    end

    assign irq = done_flag | lw_flag;

    a_r8_done_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_irq_en && !done_flag) |=> !done_flag);
    a_r9_lw_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!lw_irq_en && !lw_flag) |=> !lw_flag);
endmodule

// File: tb/tb_pulse_group_pwm.sv
module tb_pulse_group_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 0, fifo_mode = 0, start = 0, polarity = 0;
    logic [7:0]  grp_len_lo = 0;
    logic [5:0]  grp_len_hi = 0;
    logic [15:0] act_len_p = 1, rest_len_p = 1, act_len_s = 1, rest_len_s = 1;
    logic        push = 0, fifo_flush = 0, done_irq_en = 0, lw_irq_en = 0;
    logic        clr_done = 0, clr_lw = 0;
    logic [15:0] push_data = 0;
    logic [3:0]  lw_level = 0;
    logic        pwm_out, fifo_empty, fifo_full, done_flag, lw_flag, irq;
    logic [3:0]  fifo_occ;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pulse_group_pwm dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fifo_mode(fifo_mode),
        .start(start), .grp_len_lo(grp_len_lo), .grp_len_hi(grp_len_hi),
        .act_len_p(act_len_p), .rest_len_p(rest_len_p),
        .act_len_s(act_len_s), .rest_len_s(rest_len_s),
        .polarity(polarity), .push(push), .push_data(push_data),
        .fifo_flush(fifo_flush), .lw_level(lw_level),
        .done_irq_en(done_irq_en), .lw_irq_en(lw_irq_en),
        .clr_done(clr_done), .clr_lw(clr_lw), .pwm_out(pwm_out),
        .fifo_occ(fifo_occ), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .done_flag(done_flag), .lw_flag(lw_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_latency(int n, int a, int r);
        return n * (a + r) + 1;
    endfunction

    function automatic int exp_active(int n, int a);
        return n * a;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr_done();
        clr_done = 1;
        tick();
        clr_done = 0;
    endtask

    // Direct-mode group: checks latency, active cycles, pulse count, idle level
    task automatic run_direct(input int n, input int a, input int r, input bit pol);
        int lat = 0, act = 0, rises = 0;
        bit prev = 0;
        polarity   = pol;
        act_len_p  = 16'(a);
        rest_len_p = 16'(r);
        {grp_len_hi, grp_len_lo} = 14'(n);
        fifo_mode = 0; run_en = 1; done_irq_en = 1;
        pulse_clr_done();
        chk(done_flag == 0, "R8 clear", done_flag, 0);
        start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        while (!done_flag && lat < 5000) begin
            bit a_now;
            a_now = (pwm_out != pol);
            if (a_now) act++;
            if (a_now && !prev) rises++;
            prev = a_now;
            lat++;
            tick();
        end
        chk(lat == exp_latency(n, a, r), n == 0 ? "R4 latency" : "R2 latency",
            lat, exp_latency(n, a, r));
        chk(act == exp_active(n, a), "R2 active cycles", act, exp_active(n, a));
        chk(rises == n, "R2 pulse count", rises, n);
        chk(pwm_out == pol, "R3 idle level", pwm_out, pol);
        chk(irq == 1, "R10 irq with flag", irq, 1);
    endtask

    task automatic do_push(input logic [15:0] d);
        push = 1; push_data = d;
        tick();
        push = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pwm_out == 0, "R1 pwm idle", pwm_out, 0);
        chk(fifo_empty == 1 && fifo_occ == 0 && fifo_full == 0, "R1 fifo", fifo_occ, 0);
        chk(done_flag == 0 && lw_flag == 0 && irq == 0, "R1 flags", irq, 0);
        rst_n = 1;
        tick();

        // R2/R3/R4 directed
        run_direct(3, 2, 3, 0);
        run_direct(1, 1, 1, 1);
        run_direct(0, 3, 2, 0);
        run_direct(4, 5, 1, 1);
        // R2 random
        for (int i = 0; i < 8; i++)
            run_direct(int'($urandom_range(0, 5)), int'($urandom_range(1, 6)),
                       int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)));

        // R8 mask off: no flag, no irq
        pulse_clr_done();
        done_irq_en = 0; polarity = 0; act_len_p = 2; rest_len_p = 2;
        {grp_len_hi, grp_len_lo} = 14'd2;
        start = 1; tick(); start = 0;
        repeat (12) tick();
        chk(done_flag == 0, "R8 masked flag", done_flag, 0);
        chk(irq == 0, "R10 irq low", irq, 0);
        done_irq_en = 1;

        // FIFO status with engine held off
        run_en = 0; fifo_mode = 1; lw_level = 4'd3; lw_irq_en = 1;
        tick(); tick();
        chk(lw_flag == 1, "R9 low-water set", lw_flag, 1);
        chk(irq == 1, "R10 irq from lw", irq, 1);
        for (int i = 0; i < 3; i++) do_push(16'd1);
        chk(fifo_occ == 3, "R6 occupancy", fifo_occ, 3);
        clr_lw = 1; tick(); clr_lw = 0; tick();
        chk(lw_flag == 0, "R9 cleared at level", lw_flag, 0);
        for (int i = 0; i < 6; i++) do_push(16'd1);
        chk(fifo_occ == 8 && fifo_full == 1, "R6 full drop", fifo_occ, 8);
        chk(fifo_empty == 0, "R6 not empty", fifo_empty, 0);
        fifo_flush = 1; push = 1; push_data = 16'd1;
        tick();
        fifo_flush = 0; push = 0;
        chk(fifo_occ == 0 && fifo_empty == 1, "R7 flush", fifo_occ, 0);
        tick();
        clr_lw = 1; tick(); clr_lw = 0;
        chk(lw_flag == 1, "R9 re-set while low", lw_flag, 1);
        lw_irq_en = 0;
        clr_lw = 1; tick(); clr_lw = 0; tick();
        chk(lw_flag == 0, "R9 gated off", lw_flag, 0);

        // R5/R11 FIFO run: primary 2x(2,1), shadow 3x(4,2) with bit15, zero, primary 1
        polarity = 0; act_len_p = 2; rest_len_p = 1; act_len_s = 4; rest_len_s = 2;
        do_push(16'h0002);
        do_push(16'hC003);
        do_push(16'h0000);
        do_push(16'h0001);
        chk(fifo_occ == 4, "R6 occupancy 4", fifo_occ, 4);
        pulse_clr_done();
        run_en = 1;
        begin
            int act = 0, rises = 0;
            bit prev = 0;
            for (int c = 0; c < 70; c++) begin
                tick();
                if (pwm_out) act++;
                if (pwm_out && !prev) rises++;
                prev = pwm_out;
            end
            chk(act == 18, "R5 active cycles", act, 18);
            chk(rises == 6, "R5 pulse count", rises, 6);
        end
        chk(fifo_empty == 1, "R5 drained", fifo_empty, 1);
        chk(done_flag == 1, "R8 flag after fifo run", done_flag, 1);
        repeat (10) begin
            tick();
            chk(pwm_out == 0, "R11 idle hold", pwm_out, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule